// File: doc/BRIEF.md
# USB Host Port Resume Sequencer

This block is the host-side state machine for one USB 2.0 root port. It handles port power, suspend, resume signalling and the return to idle. Software works it through a small set of control bits:

- port power
- suspend
- force-resume
- run/stop
- a port-change flag that software clears by writing 1

A PHY abstraction supplies the decoded line state. The block drives back a K request, an SE0 request, a frame-start enable and the current port state.

Resume is timed entirely in hardware. Resume can start in two ways: software sets force-resume, or the attached device pulls the line from J to K while the port is suspended. The port then drives K for a fixed, parameterized number of cycles. After that it drives SE0 for a short end-of-resume interval. It then drops back to the idle state it held before suspend. Force-resume and suspend clear on their own at that moment. Because the frame-start enable depends only on the run bit and the idle state, the first frame can follow the end of resume at once. This keeps a high-speed device from falling back to full speed.

Top module: `usb_port_wake_seq`

## Requirements
- R1: After reset, force-resume, suspend, power, run and port-change all read 0, `port_state` is 0 (off), and `drive_k`, `drive_se0` and `sof_en` are 0.
- R2: A control write takes the power bit from `sc_wdata[2]`. With power at 1, an off port enters high-speed idle (`port_state` 2) when `dev_hs` is 1, and full-speed idle (`port_state` 1) otherwise. Writing power 0 returns the port to off (0) on that edge and makes force-resume and suspend read 0.
- R3: A control write with `sc_wdata[1]`=1 while in idle moves the port to suspended (`port_state` 3) and sets suspend. A write with that bit at 0 leaves suspend unchanged.
- R4: While suspended, a control write with `sc_wdata[0]`=1 and `sc_wdata[2]`=1 sets force-resume and enters resume-K (`port_state` 4) without setting port-change.
- R5: While suspended, a `line_state` of K (2'b10) in the cycle after J (2'b01) sets force-resume and port-change on the same edge. A K that follows any other line state does not.
- R6: `drive_k` is 1 for exactly RESUME_CYCLES cycles per resume, and only in resume-K.
- R7: Resume-K is followed by exactly EOR_CYCLES cycles of `drive_se0` in end-of-resume (`port_state` 5).
- R8: When end-of-resume finishes, force-resume and suspend clear on the same edge that the port enters idle. The port enters high-speed idle if it was in high-speed idle when suspended, and full-speed idle otherwise.
- R9: Writing 0 to force-resume while it is set has no effect.
- R10: `sof_en` is 1 exactly when run (set by `cmd_wr` with `cmd_run`), power and an idle state are all present. It is therefore high in the first cycle after resume ends.
- R11: Writing 1 to `sc_wdata[3]` clears port-change. A wake event on the same edge wins, and the flag stays set.
- R12: A force-resume write while the port is not suspended is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sc_wr | input | 1 | Port control write strobe |
| sc_wdata | input | 4 | Write data: [0] force-resume, [1] suspend, [2] power, [3] port-change clear |
| cmd_wr | input | 1 | Run/stop write strobe |
| cmd_run | input | 1 | Run/stop write value |
| line_state | input | 2 | Decoded line: 00 SE0, 01 J, 10 K, 11 SE1 |
| dev_hs | input | 1 | Device operates at high speed |
| rd_force | output | 1 | Force-resume bit |
| rd_suspend | output | 1 | Suspend bit |
| rd_power | output | 1 | Power bit |
| rd_run | output | 1 | Run/stop bit |
| rd_pcd | output | 1 | Port-change flag |
| drive_k | output | 1 | Request to drive full-speed K |
| drive_se0 | output | 1 | Request to drive SE0 |
| sof_en | output | 1 | Frame-start enable |
| port_state | output | 3 | 0 off, 1 FS idle, 2 HS idle, 3 suspended, 4 resume-K, 5 end-of-resume |

## Verification
The bench builds the block with RESUME_CYCLES=40 and EOR_CYCLES=4 instead of the millisecond-scale defaults. With these values a full resume lasts a few dozen cycles. The bench can therefore count every K and SE0 cycle exactly and reach the return to idle through both the high-speed and the full-speed paths within one short run. The short windows also let register writes land in the middle of resume-K, which covers the ignored zero write and the clash between a set and a clear of the port-change flag.

// File: rtl/usb_port_wake_seq.sv
module usb_port_wake_seq #(
  parameter int RESUME_CYCLES = 1_200_000,
  parameter int EOR_CYCLES    = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sc_wr,
  input  logic [3:0] sc_wdata,
  input  logic       cmd_wr,
  input  logic       cmd_run,
  input  logic [1:0] line_state,
  input  logic       dev_hs,
  output logic       rd_force,
  output logic       rd_suspend,
  output logic       rd_power,
  output logic       rd_run,
  output logic       rd_pcd,
  output logic       drive_k,
  output logic       drive_se0,
  output logic       sof_en,
  output logic [2:0] port_state
);
  localparam int CNT_MAX = (RESUME_CYCLES > EOR_CYCLES) ? RESUME_CYCLES : EOR_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [2:0] ST_OFF  = 3'd0;
  localparam logic [2:0] ST_FS   = 3'd1;
  localparam logic [2:0] ST_HS   = 3'd2;
  localparam logic [2:0] ST_SUSP = 3'd3;
  localparam logic [2:0] ST_RK   = 3'd4;
  localparam logic [2:0] ST_EOR  = 3'd5;

  localparam logic [1:0] LN_J = 2'b01;
  localparam logic [1:0] LN_K = 2'b10;

  logic [2:0]       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       line_q;
  logic             force_q, susp_q, pwr_q, run_q, pcd_q, was_hs_q;

  wire pwr_next    = sc_wr ? sc_wdata[2] : pwr_q;
  wire in_idle     = (st_q == ST_FS) || (st_q == ST_HS);
  wire in_susp     = (st_q == ST_SUSP);
  wire remote_wake = in_susp && pwr_next && (line_q == LN_J) && (line_state == LN_K);
  wire sw_resume   = in_susp && sc_wr && sc_wdata[0] && sc_wdata[2];
  wire cnt_zero    = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OFF;
      cnt_q    <= '0;
      line_q   <= 2'b00;
      force_q  <= 1'b0;
      susp_q   <= 1'b0;
      pwr_q    <= 1'b0;
      run_q    <= 1'b0;
      pcd_q    <= 1'b0;
      was_hs_q <= 1'b0;
    end else begin
      line_q <= line_state;
      pwr_q  <= pwr_next;
      if (cmd_wr) run_q <= cmd_run;

      if (remote_wake)                pcd_q <= 1'b1;
      else if (sc_wr && sc_wdata[3])  pcd_q <= 1'b0;

      if (!pwr_next) begin
        st_q    <= ST_OFF;
        force_q <= 1'b0;
        susp_q  <= 1'b0;
        cnt_q   <= '0;
      end else begin
        case (st_q)
          ST_OFF: st_q <= dev_hs ? ST_HS : ST_FS;
          ST_FS, ST_HS: begin
            if (sc_wr && sc_wdata[1]) begin
              st_q     <= ST_SUSP;
              susp_q   <= 1'b1;
              was_hs_q <= (st_q == ST_HS);
            end
          end
          ST_SUSP: begin
            if (remote_wake || sw_resume) begin
              st_q    <= ST_RK;
              force_q <= 1'b1;
              cnt_q   <= CNT_W'(RESUME_CYCLES - 1);
            end
          end
          ST_RK: begin
            if (cnt_zero) begin
              st_q  <= ST_EOR;
              cnt_q <= CNT_W'(EOR_CYCLES - 1);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_EOR: begin
            if (cnt_zero) begin
              st_q    <= was_hs_q ? ST_HS : ST_FS;
              force_q <= 1'b0;
              susp_q  <= 1'b0;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: st_q <= ST_OFF;
        endcase
      end
    end
  end

  assign rd_force   = force_q & pwr_q;
  assign rd_suspend = susp_q;
  assign rd_power   = pwr_q;
  assign rd_run     = run_q;
  assign rd_pcd     = pcd_q;
  assign drive_k    = (st_q == ST_RK);
  assign drive_se0  = (st_q == ST_EOR);
  assign sof_en     = run_q && pwr_q && in_idle;
  assign port_state = st_q;
endmodule

// File: rtl/usb_port_wake_seq_chk.sv
module usb_port_wake_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sc_wr,
  input logic [3:0] sc_wdata,
  input logic [1:0] line_state,
  input logic       rd_force,
  input logic       rd_power,
  input logic       rd_run,
  input logic       rd_pcd,
  input logic       drive_k,
  input logic       drive_se0,
  input logic       sof_en,
  input logic [2:0] port_state
);
  assert_k_with_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_k |-> (rd_force && port_state == 3'd4));

  assert_se0_in_eor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_se0 |-> (rd_force && port_state == 3'd5));

  assert_off_no_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_power |-> (!rd_force && port_state == 3'd0));

  assert_wake_sets_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_state == 3'd3 && $past(line_state) == 2'b01 && line_state == 2'b10
     && !(sc_wr && !sc_wdata[2])) |=> (rd_force && rd_pcd));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (port_state == 3'd3 && $past(line_state) == 2'b01 && line_state == 2'b10
     && sc_wr && sc_wdata[2] && sc_wdata[3]) |=> rd_pcd);

  assert_zero_write_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_state == 3'd4 && sc_wr && sc_wdata[2] && !sc_wdata[0]) |=> rd_force);

  assert_sof_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_force) && rd_power && rd_run) |-> sof_en);
endmodule

bind usb_port_wake_seq usb_port_wake_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sc_wr(sc_wr), .sc_wdata(sc_wdata),
  .line_state(line_state), .rd_force(rd_force), .rd_power(rd_power),
  .rd_run(rd_run), .rd_pcd(rd_pcd), .drive_k(drive_k), .drive_se0(drive_se0),
  .sof_en(sof_en), .port_state(port_state)
);

// File: tb/usb_port_wake_seq_tb_top.sv
`timescale 1ns/1ps
module usb_port_wake_seq_tb_top;
  localparam int RES = 40;
  localparam int EOR = 4;
  localparam int NV  = 12;
  // {wr, wdata[3:0], line[1:0], hs, exp_state[2:0], exp_force, exp_susp, exp_pcd}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 4'b0100, 2'b01, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 4'b0101, 2'b01, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 4'b0110, 2'b01, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0},
    {1'b1, 4'b0100, 2'b01, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0},
    {1'b0, 4'b0000, 2'b10, 1'b1, 3'd4, 1'b1, 1'b1, 1'b1},
    {1'b1, 4'b0100, 2'b10, 1'b1, 3'd4, 1'b1, 1'b1, 1'b1},
    {1'b1, 4'b1100, 2'b10, 1'b1, 3'd4, 1'b1, 1'b1, 1'b0},
    {1'b1, 4'b0000, 2'b10, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0},
    {1'b1, 4'b0100, 2'b01, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0},
    {1'b1, 4'b0110, 2'b01, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0},
    {1'b0, 4'b0000, 2'b00, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0},
    {1'b0, 4'b0000, 2'b10, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0}
  };
  localparam string VREQ [NV] = '{"R2", "R12", "R3", "R3", "R5", "R9",
                                  "R11", "R2", "R2", "R3", "R3", "R5"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sc_wr = 1'b0, cmd_wr = 1'b0, cmd_run = 1'b0, dev_hs = 1'b0;
  logic [3:0] sc_wdata = '0;
  logic [1:0] line_state = 2'b01;
  logic rd_force, rd_suspend, rd_power, rd_run, rd_pcd, drive_k, drive_se0, sof_en;
  logic [2:0] port_state;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  usb_port_wake_seq #(.RESUME_CYCLES(RES), .EOR_CYCLES(EOR)) dut_i (
    .clk(clk), .rst_n(rst_n), .sc_wr(sc_wr), .sc_wdata(sc_wdata),
    .cmd_wr(cmd_wr), .cmd_run(cmd_run), .line_state(line_state), .dev_hs(dev_hs),
    .rd_force(rd_force), .rd_suspend(rd_suspend), .rd_power(rd_power),
    .rd_run(rd_run), .rd_pcd(rd_pcd), .drive_k(drive_k), .drive_se0(drive_se0),
    .sof_en(sof_en), .port_state(port_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    sc_wr  = 1'b0;
    cmd_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Counts K and SE0 cycles from the current sample until the port reaches idle.
  task automatic run_resume(output int kc, output int sc);
    kc = 0;
    sc = 0;
    for (int i = 0; i < RES + EOR + 10; i++) begin
      if (port_state == 3'd1 || port_state == 3'd2) break;
      if (drive_k) kc++;
      if (drive_se0) sc++;
      step();
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int kc, sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", port_state, 0);
    chk("R1 bits", {rd_force, rd_suspend, rd_power, rd_run, rd_pcd}, 0);
    chk("R1 drives", {drive_k, drive_se0, sof_en}, 0);

    for (int i = 0; i < NV; i++) begin
      sc_wr      = VEC[i][13];
      sc_wdata   = VEC[i][12:9];
      line_state = VEC[i][8:7];
      dev_hs     = VEC[i][6];
      step();
      chk({VREQ[i], " state"}, port_state, int'(VEC[i][5:3]));
      chk({VREQ[i], " force"}, rd_force, VEC[i][2]);
      chk({VREQ[i], " susp"}, rd_suspend, VEC[i][1]);
      chk({VREQ[i], " pcd"}, rd_pcd, VEC[i][0]);
    end

    // Software resume from full-speed suspend with run set
    cmd_wr = 1'b1; cmd_run = 1'b1; line_state = 2'b01;
    step();
    chk("R10 no sof while suspended", sof_en, 0);
    sc_wr = 1'b1; sc_wdata = 4'b0101;
    step();
    chk("R4 resume entered", port_state, 4);
    chk("R4 force set", rd_force, 1);
    chk("R4 no pcd", rd_pcd, 0);
    run_resume(kc, sc);
    chk("R6 K cycles", kc, RES);
    chk("R7 SE0 cycles", sc, EOR);
    chk("R8 FS idle", port_state, 1);
    chk("R8 bits cleared", {rd_force, rd_suspend}, 0);
    chk("R10 sof on idle", sof_en, 1);

    // Remote wake from high-speed suspend, clear collides with set
    sc_wr = 1'b1; sc_wdata = 4'b0000;
    step();
    chk("R2 power off", port_state, 0);
    cmd_wr = 1'b1; cmd_run = 1'b0;
    sc_wr = 1'b1; sc_wdata = 4'b0100; dev_hs = 1'b1;
    step();
    chk("R2 HS idle", port_state, 2);
    chk("R10 run clear", sof_en, 0);
    sc_wr = 1'b1; sc_wdata = 4'b0110;
    step();
    line_state = 2'b10; sc_wr = 1'b1; sc_wdata = 4'b1100;
    step();
    chk("R11 set wins", rd_pcd, 1);
    chk("R5 force set", rd_force, 1);
    run_resume(kc, sc);
    chk("R6 K cycles hs", kc, RES);
    chk("R8 HS idle", port_state, 2);
    chk("R10 no sof without run", sof_en, 0);
    sc_wr = 1'b1; sc_wdata = 4'b1100;
    step();
    chk("R11 w1c", rd_pcd, 0);
    finish_run();
  end
endmodule